// File: doc/BRIEF.md
# Charge Pump Current Fastlock Controller

This block chooses the 3-bit current code that the charge pump uses. A steady-state code is used while the loop is settled, and a larger acquisition code is used for a while after a new frequency is programmed. The block takes these register fields as inputs: both current codes, the gain request bit, the fastlock enable and mode bits, a 4-bit timeout code, a three-state bit and a polarity bit. It also takes a one-cycle strobe per phase detector cycle, a hold signal raised by power-down or counter reset, and a strobe that marks a software write of the gain request bit.

Two acquisition modes are supported. In the software mode the acquisition code stays selected for as long as the gain request bit is 1. In the timed mode, a write of 1 to the gain request bit starts a counter of phase detector cycles. When the timeout is reached, the block goes back to the steady-state code and sends a one-cycle clear pulse to the register that holds the gain request bit. Every output is registered, so the outputs follow their inputs one clock later.

Top module: `cp_fastlock_ctrl`

## Requirements
- R1: While rst_n is low, cp_code is 0, cp_hiz is 1, cp_pol is 0 and gain_clr is 0.
- R2: When fl_en is 0, cp_code equals cur_slow from the previous cycle, whatever the value of gain_req.
- R3: When fl_en is 1, fl_mode is 0 (software mode) and hold_rst is 0, cp_code equals the previous cycle's cur_fast if gain_req was 1, and cur_slow if it was 0.
- R4: When fl_en is 1 and fl_mode is 1 (timed mode), a cycle with gain_wr=1 and gain_req=1 selects cur_fast from the next cycle. The selection lasts until the edge that samples the (3 + 4*tmo_code)-th pd_tick that follows the write. That edge brings cp_code back to cur_slow, so the timeout ranges from 3 to 63 ticks.
- R5: gain_clr rises on the same edge on which a timed-mode timeout expires, and it stays high for exactly one cycle.
- R6: In timed mode, a second write of gain_req=1 while a timeout is running restarts the count from zero.
- R7: The timeout counter runs only in timed mode. gain_clr is never raised in the cycle after a cycle with fl_en=0 or fl_mode=0.
- R8: hold_rst=1 reloads the timeout counter. On the next cycle the block gives cp_hiz=1, cp_code=cur_slow and gain_clr=0, and a count that was running is dropped.
- R9: cp_hiz equals the previous cycle's (tri_bit OR hold_rst), and cp_pol equals the previous cycle's pol_bit.
- R10: In timed mode, a write with gain_req=0 stops a running timeout. The block returns to cur_slow and gives no gain_clr pulse.
- R11: In timed mode, gain_req=1 with no starting write (for example, after the mode was switched) selects cur_slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_slow | input | 3 | Steady-state current code |
| cur_fast | input | 3 | Acquisition current code |
| gain_req | input | 1 | Current value of the gain request bit |
| gain_wr | input | 1 | One-cycle strobe: gain_req was just written |
| fl_en | input | 1 | Fastlock enable |
| fl_mode | input | 1 | 0 = software mode, 1 = timed mode |
| tmo_code | input | 4 | Timeout code k, timeout = 3 + 4k ticks |
| tri_bit | input | 1 | Force charge pump to high impedance |
| pol_bit | input | 1 | Phase detector polarity |
| pd_tick | input | 1 | One-cycle strobe per phase detector cycle |
| hold_rst | input | 1 | Power-down or counter reset |
| cp_code | output | 3 | Active current code |
| cp_hiz | output | 1 | Charge pump high-impedance flag |
| cp_pol | output | 1 | Registered polarity |
| gain_clr | output | 1 | One-cycle clear pulse for the gain request bit |

## Verification
The hardest states to reach are at the edge of a timed-mode timeout. These include the exact tick on which the count expires, a restart write that arrives late in a long count, and a hold or stop that lands while the count is running. Random stimulus seldom lines these up. Directed sequences therefore run the longest and shortest timeouts with a tick in every cycle, and they count the ticks until the clear pulse appears. Further directed sequences place a restart, a stop and a hold in the middle of a count. A long run of seeded random traffic with rare writes and holds then covers the combinations of these events.

// File: rtl/cpfl_pkg.sv
package cpfl_pkg;
    parameter int unsigned CODE_W   = 3;
    parameter int unsigned TMO_W    = 4;
    parameter int unsigned TMO_BASE = 3;
    parameter int unsigned TMO_STEP = 4;
    localparam int unsigned TMO_MAX = TMO_BASE + TMO_STEP * ((1 << TMO_W) - 1);
    localparam int unsigned CNT_W   = $clog2(TMO_MAX + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              hiz;
        logic              pol;
        logic              clr;
    } drv_st_t;
endpackage

// File: rtl/cpfl_timer.sv
module cpfl_timer
    import cpfl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             mode2,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    input  logic [TMO_W-1:0] tmo_code,
    output logic             run_nx,
    output logic             expire
);
    tmr_st_t          st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        limit   = CNT_W'(TMO_BASE) + CNT_W'(TMO_STEP) * CNT_W'(tmo_code);
        cnt_inc = st_q.cnt + CNT_W'(1);
        st_d    = st_q;
        expire  = 1'b0;
        if (hold || !mode2) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (start) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (stop) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.run && tick) begin
            if (cnt_inc == limit) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
        run_nx = st_d.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cpfl_drive.sv
module cpfl_drive
    import cpfl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_fast,
    input  logic [CODE_W-1:0] cur_slow,
    input  logic [CODE_W-1:0] cur_fast,
    input  logic              force_hiz,
    input  logic              pol_in,
    input  logic              expire,
    output logic [CODE_W-1:0] code,
    output logic              hiz,
    output logic              pol,
    output logic              clr
);
    drv_st_t st_d, st_q;
    logic [CODE_W-1:0] mux_code;

    genvar b;
    generate
        for (b = 0; b < CODE_W; b++) begin : g_bit
            assign mux_code[b] = sel_fast ? cur_fast[b] : cur_slow[b];
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.code = mux_code;
        st_d.hiz  = force_hiz;
        st_d.pol  = pol_in;
        st_d.clr  = expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.hiz  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign hiz  = st_q.hiz;
    assign pol  = st_q.pol;
    assign clr  = st_q.clr;
endmodule

// File: rtl/cp_fastlock_ctrl.sv
module cp_fastlock_ctrl
    import cpfl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cur_slow,
    input  logic [CODE_W-1:0] cur_fast,
    input  logic              gain_req,
    input  logic              gain_wr,
    input  logic              fl_en,
    input  logic              fl_mode,
    input  logic [TMO_W-1:0]  tmo_code,
    input  logic              tri_bit,
    input  logic              pol_bit,
    input  logic              pd_tick,
    input  logic              hold_rst,
    output logic [CODE_W-1:0] cp_code,
    output logic              cp_hiz,
    output logic              cp_pol,
    output logic              gain_clr
);
    logic mode2, start, stop, run_nx, expire, sel_fast;

    always_comb begin
        mode2    = fl_en & fl_mode;
        start    = gain_wr & gain_req & mode2;
        stop     = gain_wr & ~gain_req;
        sel_fast = fl_en & gain_req & ~hold_rst & (~fl_mode | run_nx);
    end

    cpfl_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold_rst),
        .mode2    (mode2),
        .start    (start),
        .stop     (stop),
        .tick     (pd_tick),
        .tmo_code (tmo_code),
        .run_nx   (run_nx),
        .expire   (expire)
    );

    cpfl_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_fast  (sel_fast),
        .cur_slow  (cur_slow),
        .cur_fast  (cur_fast),
        .force_hiz (tri_bit | hold_rst),
        .pol_in    (pol_bit),
        .expire    (expire),
        .code      (cp_code),
        .hiz       (cp_hiz),
        .pol       (cp_pol),
        .clr       (gain_clr)
    );
endmodule

// File: rtl/cpfl_chk.sv
module cpfl_chk
    import cpfl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] cur_slow,
    input logic [CODE_W-1:0] cur_fast,
    input logic              gain_req,
    input logic              gain_wr,
    input logic              fl_en,
    input logic              fl_mode,
    input logic              tri_bit,
    input logic              pol_bit,
    input logic              hold_rst,
    input logic [CODE_W-1:0] cp_code,
    input logic              cp_hiz,
    input logic              cp_pol,
    input logic              gain_clr
);
    a_r1_reset_hiz: assert property (@(posedge clk) !rst_n |=> (cp_hiz || rst_n));

    a_r2_disabled_slow: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_en |=> cp_code == $past(cur_slow));

    a_r3_sw_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && !fl_mode && !hold_rst) |=>
        cp_code == ($past(gain_req) ? $past(cur_fast) : $past(cur_slow)));

    a_r5_clr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        gain_clr |=> !gain_clr);

    a_r7_no_clr_outside_timed: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_en && fl_mode) |=> !gain_clr);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst |=> (cp_hiz && !gain_clr && cp_code == $past(cur_slow)));

    a_r9_hiz_pol: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cp_hiz == ($past(tri_bit) || $past(hold_rst)) && cp_pol == $past(pol_bit)));

    a_r10_stop_write: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_wr && !gain_req) |=> (!gain_clr && cp_code == $past(cur_slow)));
endmodule

bind cp_fastlock_ctrl cpfl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_slow (cur_slow),
    .cur_fast (cur_fast),
    .gain_req (gain_req),
    .gain_wr  (gain_wr),
    .fl_en    (fl_en),
    .fl_mode  (fl_mode),
    .tri_bit  (tri_bit),
    .pol_bit  (pol_bit),
    .hold_rst (hold_rst),
    .cp_code  (cp_code),
    .cp_hiz   (cp_hiz),
    .cp_pol   (cp_pol),
    .gain_clr (gain_clr)
);

// File: tb/tb_cp_fastlock_ctrl.sv
module tb_cp_fastlock_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cur_slow = '0, cur_fast = '0;
    logic       gain_req = 0, gain_wr = 0, fl_en = 0, fl_mode = 0;
    logic [3:0] tmo_code = '0;
    logic       tri_bit = 0, pol_bit = 0, pd_tick = 0, hold_rst = 0;
    logic [2:0] cp_code;
    logic       cp_hiz, cp_pol, gain_clr;

    int vectors = 0;
    int errors  = 0;

    // expected-value state
    bit         m_run = 0;
    int         m_cnt = 0;
    logic [2:0] e_code = 0;
    logic       e_hiz = 1, e_pol = 0, e_clr = 0;
    string      tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    cp_fastlock_ctrl dut (.*);

    function automatic int tmo_len(input logic [3:0] k);
        return 3 + 4 * int'(k);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit m2, done, fast;
        m2   = fl_en && fl_mode;
        done = 0;
        if (hold_rst || !m2) begin
            m_run = 0; m_cnt = 0;
        end else if (gain_wr && gain_req) begin
            m_run = 1; m_cnt = 0;
        end else if (gain_wr && !gain_req) begin
            m_run = 0; m_cnt = 0;
        end else if (m_run && pd_tick) begin
            m_cnt++;
            if (m_cnt == tmo_len(tmo_code)) begin
                m_run = 0; m_cnt = 0; done = 1;
            end
        end
        fast   = fl_en && gain_req && !hold_rst && (!fl_mode || m_run);
        e_code = fast ? cur_fast : cur_slow;
        e_hiz  = tri_bit || hold_rst;
        e_pol  = pol_bit;
        e_clr  = done;
    endtask

    task automatic compare_all();
        chk(tag, "cp_code",  int'(cp_code),  int'(e_code));
        chk(tag, "cp_hiz",   int'(cp_hiz),   int'(e_hiz));
        chk(tag, "cp_pol",   int'(cp_pol),   int'(e_pol));
        chk(tag, "gain_clr", int'(gain_clr), int'(e_clr));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        gain_wr = 0;
    endtask

    // timed-mode run with a tick every cycle; returns ticks until the clear pulse
    task automatic timed_run(input logic [3:0] k, output int ticks);
        fl_en = 1; fl_mode = 1; tmo_code = k; hold_rst = 0;
        cur_slow = 3'd1; cur_fast = 3'd6;
        gain_req = 1; gain_wr = 1; pd_tick = 0;
        step();
        ticks = 0;
        pd_tick = 1;
        for (int i = 0; i < 80; i++) begin
            ticks++;
            step();
            if (gain_clr) break;
            chk("R4", "fast during count", int'(cp_code), 6);
        end
        pd_tick = 0;
        chk("R4", "slow after timeout", int'(cp_code), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1", "reset code", int'(cp_code), 0);
        chk("R1", "reset hiz", int'(cp_hiz), 1);
        chk("R1", "reset pol", int'(cp_pol), 0);
        chk("R1", "reset clr", int'(gain_clr), 0);
        rst_n = 1;

        // R2: disabled, gain_req ignored
        tag = "R2";
        fl_en = 0; gain_req = 1; cur_slow = 3'd2; cur_fast = 3'd7;
        step();
        chk("R2", "disabled uses slow", int'(cp_code), 2);

        // R3: software mode
        tag = "R3";
        fl_en = 1; fl_mode = 0; gain_req = 1; gain_wr = 1;
        step();
        chk("R3", "sw fast", int'(cp_code), 7);
        pd_tick = 1;
        repeat (70) step();
        chk("R7", "no clr in sw mode", int'(gain_clr), 0);
        chk("R3", "sw still fast", int'(cp_code), 7);
        gain_req = 0; gain_wr = 1; pd_tick = 0;
        step();
        chk("R3", "sw back to slow", int'(cp_code), 2);

        // R4/R5: shortest and longest timeouts
        tag = "R4";
        timed_run(4'd0, n);
        chk("R4", "ticks k=0", n, 3);
        chk("R5", "clr high", int'(gain_clr), 1);
        step();
        chk("R5", "clr one cycle", int'(gain_clr), 0);
        timed_run(4'd15, n);
        chk("R4", "ticks k=15", n, 63);
        timed_run(4'd5, n);
        chk("R4", "ticks k=5", n, 23);

        // R6: restart late in the count
        tag = "R6";
        tmo_code = 4'd2; gain_req = 1; gain_wr = 1;
        step();
        pd_tick = 1;
        repeat (9) step();
        pd_tick = 0; gain_wr = 1;
        step();
        pd_tick = 1; n = 0;
        for (int i = 0; i < 40; i++) begin
            n++;
            step();
            if (gain_clr) break;
        end
        pd_tick = 0;
        chk("R6", "ticks after restart", n, 11);

        // R10: stop write mid-count
        tag = "R10";
        gain_req = 1; gain_wr = 1;
        step();
        pd_tick = 1;
        repeat (4) step();
        gain_req = 0; gain_wr = 1;
        step();
        chk("R10", "stop gives slow", int'(cp_code), 1);
        repeat (20) step();
        chk("R10", "no clr after stop", int'(gain_clr), 0);

        // R8: hold mid-count
        tag = "R8";
        gain_req = 1; gain_wr = 1; pd_tick = 0;
        step();
        pd_tick = 1;
        repeat (5) step();
        hold_rst = 1;
        step();
        chk("R8", "hold hiz", int'(cp_hiz), 1);
        chk("R8", "hold slow", int'(cp_code), 1);
        hold_rst = 0;
        repeat (20) step();
        chk("R8", "count dropped", int'(gain_clr), 0);
        // R11: gain_req high without a starting write
        chk("R11", "no write gives slow", int'(cp_code), 1);

        // R9: tri-state and polarity
        tag = "R9";
        tri_bit = 1; pol_bit = 1;
        step();
        chk("R9", "tri hiz", int'(cp_hiz), 1);
        chk("R9", "pol", int'(cp_pol), 1);
        tri_bit = 0; pol_bit = 0;
        step();
        chk("R9", "hiz released", int'(cp_hiz), 0);
        pd_tick = 0;

        // random traffic
        for (int i = 0; i < 20000; i++) begin
            cur_slow = 3'($urandom);
            if (($urandom % 8) == 0) cur_fast = 3'($urandom);
            if (($urandom % 200) == 0) fl_en = ~fl_en;
            if (($urandom % 300) == 0) fl_mode = ~fl_mode;
            if (($urandom % 150) == 0) tmo_code = 4'($urandom);
            gain_wr = (($urandom % 40) == 0);
            if (gain_wr) gain_req = (($urandom % 4) != 0);
            tri_bit  = (($urandom % 50) == 0);
            pol_bit  = 1'($urandom);
            pd_tick  = (($urandom % 3) != 0);
            hold_rst = (($urandom % 500) == 0);
            tag = !fl_en ? "R2" : (!fl_mode ? "R3" : "R4");
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule